// File: doc/BRIEF.md
# Burst-of-Two Quad-Rate SRAM Model

This block is a synthesizable behavioural model of a quad-data-rate static memory with an independent read port and write port. Every transaction moves two 18-bit beats. The model runs on one clock at twice the memory cycle rate. An input phase flag marks each edge as either the primary edge (`k_edge` high, standing for the K rise) or the complementary edge (`k_edge` low, standing for the K# rise). The environment toggles this flag on every clock.

A read is taken on a primary edge together with its address. Its two beats come back on the data-out bus two and three edges later, with a drive flag raised. A write is also started on a primary edge, and its first data beat and byte mask are taken on that same edge. The write address, the second beat and the second mask are taken on the complementary edge that follows. The shared address bus therefore carries a read address and a write address in every memory cycle.

A finished write is posted into a single write register. It reaches the 36-bit array only when the next write finishes. Reads that hit the posted entry get its byte lanes merged over the array contents, so a read always returns the most recent data.

Top module: `qdr_b2_sram`

## Requirements
- R1: While reset is low, and on the first edge after it is released, `q_drive` is low and `q` is zero.
- R2: A read taken on a primary edge with `rd_n` low presents beat 0 (word bits 17:0) on `q` after the next primary edge, two clocks later. Beat 1 (word bits 35:18) follows one clock after that. `q_drive` is high for both beats.
- R3: When no read beat is being delivered, `q_drive` is low and `q` is all zeros.
- R4: A write is started by `wr_n` low on a primary edge, which also takes beat 0 from `d`. The following complementary edge takes the write address and beat 1. Beat 0 is stored in bits 17:0 of the word and beat 1 in bits 35:18.
- R5: `bw_n[0]` low enables beat bits 8:0 and `bw_n[1]` low enables beat bits 17:9. Each beat carries its own mask. A lane whose enable is high keeps its stored value.
- R6: A read of an address whose write finished on the complementary edge just before returns the new data.
- R7: A read that hits a posted partial write returns the written lanes merged with the older stored lanes.
- R8: Reads issued on consecutive primary edges give an unbroken stream of beats on `q`, in issue order.
- R9: When `rd_n` and `wr_n` are both low on the same primary edge, the read returns the contents from before that write, and the write still takes effect for later reads.
- R10: `rd_n` and `wr_n` low on a complementary edge start nothing: no beat is driven and no word changes.
- R11: Writes started on consecutive primary edges are all stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; each rising edge is one half of a memory cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| k_edge | input | 1 | High: this edge is a primary edge; low: complementary edge |
| rd_n | input | 1 | Active-low read request, taken on primary edges |
| wr_n | input | 1 | Active-low write request, taken on primary edges |
| addr | input | AW | Read address on primary edges, write address on complementary edges |
| d | input | 18 | Write data beat |
| bw_n | input | 2 | Active-low lane enables for the current beat |
| q | output | 18 | Read data beat, zero when not driven |
| q_drive | output | 1 | High while a read beat is on `q` |

## Verification
Beat 0 of a read is due two clocks after the primary edge that took it, and beat 1 is due one clock later. Both are sampled on the falling clock edge that follows each rising edge that updates them. Each directed memory cycle of the bench checks the beats of the read issued in the cycle before. Expected words come from a reference array in the bench. That array is read before the current cycle's write is applied and updated after it, which gives the forwarding and same-edge behaviour without any reference to the design's write register.

// File: rtl/qdr_b2_pkg.sv
// Package: shared widths and word types for the burst-of-two SRAM model.
// Assumes a beat splits evenly into 9-bit byte lanes.
package qdr_b2_pkg;
    localparam int BEAT_W         = 18;
    localparam int LANE_W         = 9;
    localparam int LANES_PER_BEAT = BEAT_W / LANE_W;
    localparam int WORD_LANES     = 2 * LANES_PER_BEAT;
    localparam int WORD_W         = 2 * BEAT_W;

    typedef logic [WORD_LANES-1:0][LANE_W-1:0] word_t;
    typedef logic [WORD_LANES-1:0]             mask_t;
    typedef logic [BEAT_W-1:0]                 beat_t;
    typedef logic [LANES_PER_BEAT-1:0]         bmask_t;
endpackage

// File: rtl/qdr_b2_wcap.sv
// Write capture: holds beat 0 and its lane mask from the primary edge.
// On the complementary edge it presents the complete write, combinationally,
// for one clock. Assumes k_edge alternates on every clock.
module qdr_b2_wcap
    import qdr_b2_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          k_edge,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  beat_t         d,
    input  bmask_t        bw_n,
    output logic          cmp_v,
    output logic [AW-1:0] cmp_addr,
    output word_t         cmp_data,
    output mask_t         cmp_mask
);
    logic   armed_q;
    beat_t  lo_q;
    bmask_t lo_m_q;

    // Arm on a primary-edge write request and keep the first beat with its mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            lo_q    <= '0;
            lo_m_q  <= '0;
        end else if (k_edge) begin
            armed_q <= !wr_n;
            if (!wr_n) begin
                lo_q   <= d;
                lo_m_q <= ~bw_n;
            end
        end else begin
            armed_q <= 1'b0;
        end
    end

    // Assemble the finished write on the complementary half cycle.
    always_comb begin
        cmp_v    = armed_q && !k_edge;
        cmp_addr = addr;
        cmp_data = word_t'({d, lo_q});
        cmp_mask = mask_t'({~bw_n, lo_m_q});
    end
endmodule

// File: rtl/qdr_b2_store.sv
// Storage: the word array plus one posted write register.
// A new finished write commits the previous posted entry lane by lane
// and takes its place. The read lookup is combinational and merges a
// matching posted entry over the array word.
// Assumes reads (primary edges) and commits (complementary edges) never coincide.
module qdr_b2_store
    import qdr_b2_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_v,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  mask_t         wr_mask,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_word
);
    localparam int DEPTH = 1 << AW;

    word_t         mem [DEPTH];
    logic          pend_v;
    logic [AW-1:0] pend_a;
    word_t         pend_d;
    mask_t         pend_m;
    word_t         arr_word;
    logic          hit;

    // Track the posted write entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_a <= '0;
            pend_d <= '0;
            pend_m <= '0;
        end else if (wr_v) begin
            pend_v <= 1'b1;
            pend_a <= wr_addr;
            pend_d <= wr_data;
            pend_m <= wr_mask;
        end
    end

    // Retire the older posted entry into the array, enabled lanes only.
    always_ff @(posedge clk) begin
        if (rst_n && wr_v && pend_v) begin
            for (int i = 0; i < WORD_LANES; i++) begin
                if (pend_m[i]) mem[pend_a][i] <= pend_d[i];
            end
        end
    end

    assign arr_word = mem[rd_addr];
    assign hit      = pend_v && (pend_a == rd_addr);

    // Per-lane forward mux: posted lanes override array lanes on a hit.
    for (genvar g = 0; g < WORD_LANES; g++) begin : g_fwd
        assign rd_word[g] = (hit && pend_m[g]) ? pend_d[g] : arr_word[g];
    end
endmodule

// File: rtl/qdr_b2_rpipe.sv
// Read pipeline: holds the looked-up word for one memory cycle, then
// puts beat 0 on the bus after the next primary edge and beat 1 after
// the complementary edge. The bus is zero whenever nothing is driven.
module qdr_b2_rpipe
    import qdr_b2_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  k_edge,
    input  logic  rd_req,
    input  word_t rd_word,
    output beat_t q,
    output logic  q_drive
);
    word_t buf_q;
    logic  buf_v;
    beat_t hi_q;

    // Stage the word, then deliver its two beats in order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            buf_v   <= 1'b0;
            hi_q    <= '0;
            q       <= '0;
            q_drive <= 1'b0;
        end else if (k_edge) begin
            buf_v   <= rd_req;
            if (rd_req) buf_q <= rd_word;
            q_drive <= buf_v;
            q       <= buf_v ? beat_t'(buf_q[LANES_PER_BEAT-1:0]) : '0;
            hi_q    <= beat_t'(buf_q[WORD_LANES-1:LANES_PER_BEAT]);
        end else begin
            q <= q_drive ? hi_q : '0;
        end
    end
endmodule

// File: rtl/qdr_b2_sram.sv
// Top: burst-of-two quad-rate SRAM model. Ties together write capture,
// storage with a posted write register, and the read pipeline.
// Assumes k_edge toggles on every clock and is high on primary edges.
module qdr_b2_sram
    import qdr_b2_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          k_edge,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [17:0]   d,
    input  logic [1:0]    bw_n,
    output logic [17:0]   q,
    output logic          q_drive
);
    logic          cmp_v;
    logic [AW-1:0] cmp_addr;
    word_t         cmp_data;
    mask_t         cmp_mask;
    word_t         rd_word;
    logic          rd_req;

    assign rd_req = k_edge && !rd_n;

    qdr_b2_wcap #(.AW(AW)) u_wcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_edge   (k_edge),
        .wr_n     (wr_n),
        .addr     (addr),
        .d        (d),
        .bw_n     (bw_n),
        .cmp_v    (cmp_v),
        .cmp_addr (cmp_addr),
        .cmp_data (cmp_data),
        .cmp_mask (cmp_mask)
    );

    qdr_b2_store #(.AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_v    (cmp_v),
        .wr_addr (cmp_addr),
        .wr_data (cmp_data),
        .wr_mask (cmp_mask),
        .rd_addr (addr),
        .rd_word (rd_word)
    );

    qdr_b2_rpipe u_rpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .k_edge  (k_edge),
        .rd_req  (rd_req),
        .rd_word (rd_word),
        .q       (q),
        .q_drive (q_drive)
    );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
// Checker: timing properties of the read bus, attached to the top by bind.
module qdr_b2_sram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        k_edge,
    input logic        rd_n,
    input logic [17:0] q,
    input logic        q_drive
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !q_drive); // R1
    AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !q_drive |-> (q == '0)); // R3
    AST_BEAT0_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (k_edge && !rd_n) |-> ##3 q_drive); // R2
    AST_BEAT1_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (k_edge && !rd_n) |-> ##4 q_drive); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_drive) |-> $past(k_edge && !rd_n, 3)); // R10
endmodule

bind qdr_b2_sram qdr_b2_sram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .k_edge  (k_edge),
    .rd_n    (rd_n),
    .q       (q),
    .q_drive (q_drive)
);

// File: tb/test_qdr_b2_sram.sv
// Directed bench: one task per scenario. A reference array gives the
// expected words: it is read before each cycle's write and updated after it.
module test_qdr_b2_sram;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          k_edge = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [17:0]   d = '0;
    logic [1:0]    bw_n = 2'b11;
    logic [17:0]   q;
    logic          q_drive;

    int nchk = 0;
    int nfail = 0;

    logic [35:0] model [1 << AW];
    bit          pv = 1'b0;
    logic [35:0] pexp = '0;
    string       ptag = "R1";

    always #2.5 clk = ~clk;

    qdr_b2_sram #(.AW(AW)) i_qdr_b2_sram (
        .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .d(d), .bw_n(bw_n), .q(q), .q_drive(q_drive)
    );

    task automatic chk(input string tag, input logic [17:0] eq, input bit ed);
        nchk++;
        if (q !== eq || q_drive !== ed) begin
            nfail++;
            $display("FAIL %s: q=%h drive=%b expected q=%h drive=%b", tag, q, q_drive, eq, ed);
        end
    endtask

    // One memory cycle; checks the beats of the read issued one cycle earlier.
    task automatic kcyc(input bit rd, input logic [AW-1:0] ra, input bit wr,
                        input logic [AW-1:0] wa, input logic [35:0] wdat,
                        input logic [3:0] wm, input bit stray, input string tag);
        logic [35:0] e;
        e = model[ra];
        k_edge = 1'b1; rd_n = !rd; wr_n = !wr; addr = ra;
        d = wdat[17:0]; bw_n = ~wm[1:0];
        @(negedge clk);
        chk(ptag, pv ? pexp[17:0] : 18'h0, pv);
        k_edge = 1'b0; rd_n = !stray; wr_n = !stray; addr = wa;
        d = stray ? 18'h2aaaa : wdat[35:18]; bw_n = stray ? 2'b00 : ~wm[3:2];
        @(negedge clk);
        chk(ptag, pv ? pexp[35:18] : 18'h0, pv);
        if (wr) for (int i = 0; i < 4; i++)
            if (wm[i]) model[wa][9*i +: 9] = wdat[9*i +: 9];
        pv = rd; pexp = e; ptag = tag;
    endtask

    task automatic idle(input string tag);
        kcyc(1'b0, '0, 1'b0, '0, '0, 4'h0, 1'b0, tag);
    endtask

    function automatic logic [35:0] pat(input int a, input int s);
        return {18'(a * 37 + s * 11 + 5), 18'(a * 101 + s * 7 + 3)};
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 18'h0, 1'b0);
    endtask

    // R4 / R11: writes on every primary edge fill addresses 0..15.
    task automatic t_fill;
        for (int a = 0; a < 16; a++)
            kcyc(1'b0, '0, 1'b1, AW'(a), pat(a, 0), 4'hF, 1'b0, "R11");
        idle("R3");
    endtask

    // R2 / R3: isolated reads with idle cycles between them.
    task automatic t_read_basic;
        kcyc(1'b1, 6'd3, 1'b0, '0, '0, 4'h0, 1'b0, "R2");
        idle("R3");
        kcyc(1'b1, 6'd0, 1'b0, '0, '0, 4'h0, 1'b0, "R4");
        idle("R3");
        idle("R3");
    endtask

    // R8: reads on consecutive primary edges.
    task automatic t_burst_reads;
        for (int a = 15; a >= 8; a--)
            kcyc(1'b1, AW'(a), 1'b0, '0, '0, 4'h0, 1'b0, "R8");
        idle("R8");
    endtask

    // R5: per-beat lane masks, checked after the entry has been committed.
    task automatic t_mask;
        kcyc(1'b0, '0, 1'b1, 6'd4, 36'hFFFFFFFFF, 4'b0110, 1'b0, "R5");
        kcyc(1'b0, '0, 1'b1, 6'd20, pat(20, 1), 4'hF, 1'b0, "R5");
        kcyc(1'b1, 6'd4, 1'b0, '0, '0, 4'h0, 1'b0, "R5");
        kcyc(1'b0, '0, 1'b1, 6'd5, 36'h0, 4'b1001, 1'b0, "R5");
        kcyc(1'b0, '0, 1'b1, 6'd21, pat(21, 1), 4'hF, 1'b0, "R5");
        kcyc(1'b1, 6'd5, 1'b0, '0, '0, 4'h0, 1'b0, "R5");
        idle("R5");
    endtask

    // R6 / R7: read right after a write to the same address.
    task automatic t_forward;
        kcyc(1'b0, '0, 1'b1, 6'd6, pat(6, 2), 4'hF, 1'b0, "R6");
        kcyc(1'b1, 6'd6, 1'b0, '0, '0, 4'h0, 1'b0, "R6");
        kcyc(1'b0, '0, 1'b1, 6'd7, 36'h123456789, 4'b0101, 1'b0, "R7");
        kcyc(1'b1, 6'd7, 1'b0, '0, '0, 4'h0, 1'b0, "R7");
        kcyc(1'b0, '0, 1'b1, 6'd8, pat(8, 3), 4'hF, 1'b0, "R7");
        kcyc(1'b1, 6'd7, 1'b0, '0, '0, 4'h0, 1'b0, "R7");
        idle("R7");
    endtask

    // R9: read and write on the same primary edge, same address.
    task automatic t_same_edge;
        kcyc(1'b1, 6'd9, 1'b1, 6'd9, pat(9, 4), 4'hF, 1'b0, "R9");
        kcyc(1'b1, 6'd9, 1'b1, 6'd10, pat(10, 4), 4'hF, 1'b0, "R9");
        kcyc(1'b1, 6'd10, 1'b0, '0, '0, 4'h0, 1'b0, "R9");
        idle("R9");
    endtask

    // R10: strobes low only on complementary edges start nothing.
    task automatic t_stray;
        kcyc(1'b0, 6'd11, 1'b0, 6'd11, '0, 4'h0, 1'b1, "R10");
        idle("R10");
        kcyc(1'b0, '0, 1'b1, 6'd30, pat(30, 5), 4'hF, 1'b0, "R10");
        kcyc(1'b1, 6'd11, 1'b0, '0, '0, 4'h0, 1'b0, "R10");
        idle("R10");
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_fill;
                t_read_basic;
                t_burst_reads;
                t_mask;
                t_forward;
                t_same_edge;
                t_stray;
            end
            begin
                repeat (100000) @(posedge clk);
                nfail++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule